// File: doc/BRIEF.md
# Synthesizer Feedback and Reference Divider Core

This block holds the two counters that feed the phase detector of a frequency synthesizer. Two slow clocks arrive as asynchronous inputs. One is the prescaled RF signal and the other is the crystal reference. Each input passes through a short synchronizer, and its rising edges are counted in the single system clock domain. The feedback counter emits one tick every N RF edges, where N is a 15-bit programmable ratio. The reference counter emits one tick every 512 or 1024 crystal edges. Each tick is one system clock wide.

A half-rate copy of the feedback tick train is kept as a level that toggles on every feedback tick. Four band-select lines normally mirror a band register. When a test flag is raised and both upper band bits are set, the upper two lines carry the reference tick and the half-rate feedback level instead. A prescaler-skip request is carried through as a plain flag.

Ratio and reference-length changes never cut a count short. The new value is taken only when the running count wraps.

Top module: `synth_divider_core`

## Requirements
- R1: `fb_tick` pulses once every N synchronized rising edges of `rf_in`, where N is the effective ratio from `div_ratio` and can range from 17 to 32767.
- R2: A `div_ratio` value below 17 is treated as 17.
- R3: With `wide_word` low, the top ratio bit (bit 14) is forced to 0, so the largest effective ratio is 16383. With `wide_word` high, all 15 bits count.
- R4: The ratio in effect is sampled at each feedback terminal count. A change in the middle of a period affects only the period that starts after the next tick.
- R5: `ref_tick` pulses once every 512 `xtal_in` rising edges when `ref_long` is 0, and once every 1024 when it is 1. The length is sampled at each reference terminal count.
- R6: `fb_tick` and `ref_tick` are each high for exactly one clock per terminal count.
- R7: `fb_half` is 0 after reset and toggles in the same cycle as each `fb_tick` pulse. It holds at all other times.
- R8: `band_out[1:0]` always equal `band_reg[1:0]`.
- R9: When `test_route` is 1 and `band_reg[3:2]` is 2'b11, `band_out[2]` equals `ref_tick` and `band_out[3]` equals `fb_half`.
- R10: In every other case `test_route` has no effect, and `band_out[3:2]` equal `band_reg[3:2]`.
- R11: `prescaler_skip_o` always equals `prescaler_skip`.
- R12: While `rst_n` is low, `fb_tick`, `ref_tick` and `fb_half` are 0. The ratio and reference length present during reset govern the first periods after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice either input edge rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_in | input | 1 | Prescaled RF signal, asynchronous |
| xtal_in | input | 1 | Crystal reference signal, asynchronous |
| div_ratio | input | 15 | Feedback division ratio |
| wide_word | input | 1 | 1: all 15 ratio bits used; 0: bit 14 forced low |
| ref_long | input | 1 | Reference length select: 0 = 512, 1 = 1024 |
| test_route | input | 1 | Test routing request for the upper band lines |
| prescaler_skip | input | 1 | Prescaler bypass request |
| band_reg | input | 4 | Band-select register bits |
| fb_tick | output | 1 | Feedback terminal-count pulse |
| ref_tick | output | 1 | Reference terminal-count pulse |
| fb_half | output | 1 | Feedback tick train divided by two |
| band_out | output | 4 | Band-select lines |
| prescaler_skip_o | output | 1 | Prescaler bypass flag |

## Verification
The bench targets four classes of error:

- **Clamp (R2):** it programs ratios of 5 and 0. A design without the floor at 17 would tick after fewer edges or never wrap.
- **Short-word masking (R3):** it sets a ratio with bit 14 high while `wide_word` is low. A design that ignores `wide_word` stalls for more than sixteen thousand edges, and the next counted interval disagrees.
- **Reload timing (R4, R5):** the ratio and reference length change in the middle of a period. A design that reloads at once truncates the current period and gives an interval that matches neither value.
- **Test routing (R9, R10):** random band patterns exercise routing with only one upper band bit set. This exposes a mux that keys on the test flag alone.

// File: rtl/synth_divider_pkg.sv
// Package: shared constants and types for the synthesizer divider core.
// Assumes: consumers size their counters from these values.
package synth_divider_pkg;

    // Smallest feedback ratio the counter will honour.
    localparam int MIN_FB_RATIO = 17;

    // Source selected for one band output lane.
    typedef enum logic {
        LANE_DIRECT = 1'b0,
        LANE_TEST   = 1'b1
    } lane_src_e;

endpackage

// File: rtl/edge_sync.sv
// Module: edge_sync
// Brings an asynchronous slow signal into the clk domain through a
// flop chain and flags each rising edge for exactly one clock.
// Assumes: the input stays at each level for at least two clk periods.
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], async_in};
        end
    end

    // A rise is the settled sample high while the one before was low.
    always_comb begin
        rise = chain[LAST-1] & ~chain[LAST];
    end

endmodule

// File: rtl/term_counter.sv
// Module: term_counter
// Counts enabled steps and emits a one-clock pulse on the step that
// completes a period of `len` steps. The length in force is captured
// during reset and again at every wrap, so a running period is never cut.
// Assumes: len is at least 2.
module term_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] len,
    output logic         tc
);

    logic [W-1:0] cnt;
    logic [W-1:0] active_len;
    logic         at_last;

    // Decode the final step of the period in force.
    always_comb begin
        at_last = (cnt == (active_len - 1'b1));
    end

    // Advance the count, wrap at the period end and take a new length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            active_len <= len;
            tc         <= 1'b0;
        end else if (step) begin
            if (at_last) begin
                cnt        <= '0;
                active_len <= len;
                tc         <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                tc  <= 1'b0;
            end
        end else begin
            tc <= 1'b0;
        end
    end

endmodule

// File: rtl/band_router.sv
// Module: band_router
// Drives the band lines. Lanes 0, 1 and any above 3 mirror the register.
// Lanes 2 and 3 carry the reference tick and the half-rate feedback level
// when test routing is requested and both of those register bits are set.
// Assumes: BAND_W is at least 4.
module band_router
    import synth_divider_pkg::*;
#(
    parameter int BAND_W = 4
) (
    input  logic [BAND_W-1:0] band_reg,
    input  logic              test_route,
    input  logic              ref_tick,
    input  logic              fb_half,
    output logic [BAND_W-1:0] band_out
);

    localparam int REF_LANE  = 2;
    localparam int HALF_LANE = 3;

    lane_src_e upper_src;

    // Routing is honoured only with both upper band bits set.
    always_comb begin
        if (test_route && band_reg[REF_LANE] && band_reg[HALF_LANE]) begin
            upper_src = LANE_TEST;
        end else begin
            upper_src = LANE_DIRECT;
        end
    end

    for (genvar i = 0; i < BAND_W; i++) begin : g_lane
        if (i == REF_LANE) begin : g_ref
            // Reference tick or register bit on lane 2.
            always_comb begin
                band_out[i] = (upper_src == LANE_TEST) ? ref_tick : band_reg[i];
            end
        end else if (i == HALF_LANE) begin : g_half
            // Half-rate feedback or register bit on lane 3.
            always_comb begin
                band_out[i] = (upper_src == LANE_TEST) ? fb_half : band_reg[i];
            end
        end else begin : g_direct
            // Plain register bit.
            always_comb begin
                band_out[i] = band_reg[i];
            end
        end
    end

endmodule

// File: rtl/synth_divider_core.sv
// Module: synth_divider_core
// Feedback and reference counters of a frequency synthesizer, with a
// half-rate feedback level and test routing onto the band lines.
// Assumes: clk samples rf_in and xtal_in at over twice their edge rate;
// ratio and length changes are picked up at each counter's wrap.
module synth_divider_core
    import synth_divider_pkg::*;
#(
    parameter int FB_W        = 15,
    parameter int REF_LOG2    = 9,
    parameter int SYNC_STAGES = 2,
    parameter int BAND_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_in,
    input  logic              xtal_in,
    input  logic [FB_W-1:0]   div_ratio,
    input  logic              wide_word,
    input  logic              ref_long,
    input  logic              test_route,
    input  logic              prescaler_skip,
    input  logic [BAND_W-1:0] band_reg,
    output logic              fb_tick,
    output logic              ref_tick,
    output logic              fb_half,
    output logic [BAND_W-1:0] band_out,
    output logic              prescaler_skip_o
);

    localparam int REF_W     = REF_LOG2 + 2;
    localparam int REF_SHORT = 1 << REF_LOG2;
    localparam int REF_LONG  = REF_SHORT * 2;
    localparam logic [FB_W-1:0]  FB_FLOOR    = FB_W'(MIN_FB_RATIO);
    localparam logic [REF_W-1:0] REF_SHORT_L = REF_W'(REF_SHORT);
    localparam logic [REF_W-1:0] REF_LONG_L  = REF_W'(REF_LONG);

    logic              rf_rise;
    logic              xtal_rise;
    logic [FB_W-1:0]   ratio_masked;
    logic [FB_W-1:0]   ratio_eff;
    logic [REF_W-1:0]  ref_len;

    edge_sync #(.STAGES(SYNC_STAGES)) u_rf_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rf_in),
        .rise     (rf_rise)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_xtal_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (xtal_in),
        .rise     (xtal_rise)
    );

    // Mask the top ratio bit in short-word mode, then apply the floor.
    always_comb begin
        ratio_masked = div_ratio;
        if (!wide_word) begin
            ratio_masked[FB_W-1] = 1'b0;
        end
        ratio_eff = (ratio_masked < FB_FLOOR) ? FB_FLOOR : ratio_masked;
    end

    // Pick the reference period length.
    always_comb begin
        ref_len = ref_long ? REF_LONG_L : REF_SHORT_L;
    end

    term_counter #(.W(FB_W)) u_fb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rf_rise),
        .len   (ratio_eff),
        .tc    (fb_tick)
    );

    term_counter #(.W(REF_W)) u_ref_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (xtal_rise),
        .len   (ref_len),
        .tc    (ref_tick)
    );

    // Divide the feedback tick train by two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_half <= 1'b0;
        end else if (u_fb_cnt.step && u_fb_cnt.at_last) begin
            fb_half <= ~fb_half;
        end
    end

    band_router #(.BAND_W(BAND_W)) u_router (
        .band_reg   (band_reg),
        .test_route (test_route),
        .ref_tick   (ref_tick),
        .fb_half    (fb_half),
        .band_out   (band_out)
    );

    // Carry the prescaler bypass request straight through.
    always_comb begin
        prescaler_skip_o = prescaler_skip;
    end

endmodule

// File: rtl/synth_divider_core_chk.sv
// Module: synth_divider_core_chk
// Property checker bound to synth_divider_core; observes ports only.
// Assumes: BAND_W of at least 4.
module synth_divider_core_chk #(
    parameter int BAND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_route,
    input logic              prescaler_skip,
    input logic [BAND_W-1:0] band_reg,
    input logic              fb_tick,
    input logic              ref_tick,
    input logic              fb_half,
    input logic [BAND_W-1:0] band_out,
    input logic              prescaler_skip_o
);

    assert_fb_tick_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> !fb_tick);

    assert_ref_tick_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    assert_half_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |-> (fb_half != $past(fb_half)));

    assert_half_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_tick |-> (fb_half == $past(fb_half)));

    assert_low_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        band_out[1:0] == band_reg[1:0]);

    assert_route_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_route && band_reg[2] && band_reg[3]) |->
            (band_out[2] == ref_tick && band_out[3] == fb_half));

    assert_route_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_route && band_reg[2] && band_reg[3]) |->
            (band_out[3:2] == band_reg[3:2]));

    assert_skip_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prescaler_skip_o == prescaler_skip);

endmodule

bind synth_divider_core synth_divider_core_chk #(.BAND_W(BAND_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .test_route       (test_route),
    .prescaler_skip   (prescaler_skip),
    .band_reg         (band_reg),
    .fb_tick          (fb_tick),
    .ref_tick         (ref_tick),
    .fb_half          (fb_half),
    .band_out         (band_out),
    .prescaler_skip_o (prescaler_skip_o)
);

// File: tb/synth_divider_core_bench.sv
`timescale 1ns/1ps
// Bench: drives both slow inputs as edge trains four clocks apart, models
// expected periods from the requirements and checks ticks and band lines.
module synth_divider_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_in = 1'b0;
    logic        xtal_in = 1'b0;
    logic [14:0] div_ratio = 15'd17;
    logic        wide_word = 1'b1;
    logic        ref_long = 1'b0;
    logic        test_route = 1'b0;
    logic        prescaler_skip = 1'b0;
    logic [3:0]  band_reg = 4'b1111;
    logic        fb_tick;
    logic        ref_tick;
    logic        fb_half;
    logic [3:0]  band_out;
    logic        prescaler_skip_o;

    int total = 0;
    int passed = 0;
    int rf_cnt = 0;
    int xtal_cnt = 0;
    int exp_fb = 17;
    int exp_ref = 512;
    bit exp_half = 1'b0;
    bit prev_fb = 1'b0;
    bit prev_ref = 1'b0;
    bit running = 1'b0;
    bit xtal_stop = 1'b0;
    bit finished = 1'b0;
    int short_ref_seen = 0;
    int long_ref_seen = 0;
    int fb_seen = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    synth_divider_core u_synth_divider_core (
        .clk              (clk),
        .rst_n            (rst_n),
        .rf_in            (rf_in),
        .xtal_in          (xtal_in),
        .div_ratio        (div_ratio),
        .wide_word        (wide_word),
        .ref_long         (ref_long),
        .test_route       (test_route),
        .prescaler_skip   (prescaler_skip),
        .band_reg         (band_reg),
        .fb_tick          (fb_tick),
        .ref_tick         (ref_tick),
        .fb_half          (fb_half),
        .band_out         (band_out),
        .prescaler_skip_o (prescaler_skip_o)
    );

    function automatic int eff_ratio(int r, bit wide);
        int v;
        v = wide ? r : (r & 16'h3FFF);
        if (v < 17) v = 17;
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (ok) passed++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic rf_edge();
        rf_in = 1'b1;
        rf_cnt++;
        tick(); tick();
        rf_in = 1'b0;
        tick(); tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", passed, total);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000) begin
            total++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
            finish_run();
        end
    end

    // Monitor sampled at the falling edge.
    always @(negedge clk) begin
        if (running) begin
            if (fb_tick) begin
                chk(!prev_fb, "R6", "fb_tick width", 1, 0);
                chk(rf_cnt == exp_fb, "R1,R2,R3,R4", "fb period", rf_cnt, exp_fb);
                exp_half = ~exp_half;
                chk(fb_half == exp_half, "R7", "fb_half toggle", fb_half, exp_half);
                exp_fb = eff_ratio(div_ratio, wide_word);
                rf_cnt = 0;
                fb_seen++;
            end else begin
                chk(fb_half == exp_half, "R7", "fb_half hold", fb_half, exp_half);
            end
            if (ref_tick) begin
                chk(!prev_ref, "R6", "ref_tick width", 1, 0);
                chk(xtal_cnt == exp_ref, "R5", "ref period", xtal_cnt, exp_ref);
                if (exp_ref == 1024) long_ref_seen++;
                else short_ref_seen++;
                exp_ref = ref_long ? 1024 : 512;
                xtal_cnt = 0;
            end
            chk(band_out[1:0] == band_reg[1:0], "R8", "low lanes", band_out[1:0], band_reg[1:0]);
            if (test_route && band_reg[3] && band_reg[2]) begin
                chk(band_out[3:2] == {exp_half, ref_tick}, "R9", "routed lanes",
                    band_out[3:2], {exp_half, ref_tick});
            end else begin
                chk(band_out[3:2] == band_reg[3:2], "R10", "direct upper lanes",
                    band_out[3:2], band_reg[3:2]);
            end
            chk(prescaler_skip_o == prescaler_skip, "R11", "skip flag",
                prescaler_skip_o, prescaler_skip);
            prev_fb = fb_tick;
            prev_ref = ref_tick;
        end
    end

    // Crystal edge train; reference length changes only at edge times.
    initial begin
        wait (running);
        for (int n = 1; !xtal_stop; n++) begin
            if (n % 1500 == 0) ref_long = ~ref_long;
            xtal_in = 1'b1;
            xtal_cnt++;
            tick(); tick();
            xtal_in = 1'b0;
            tick(); tick();
        end
    end

    // Random band, test and skip patterns.
    initial begin
        wait (running);
        while (!xtal_stop) begin
            band_reg = ($urandom % 2 == 0) ? 4'b1100 | 4'($urandom % 4) : 4'($urandom % 16);
            test_route = 1'($urandom % 2);
            prescaler_skip = 1'($urandom % 2);
            repeat (1 + $urandom % 20) tick();
        end
    end

    // Main sequence.
    initial begin
        void'($urandom(32'h5EED_1234));
        // R12: outputs during reset, values sampled in reset rule first periods.
        div_ratio = 15'd17;
        wide_word = 1'b1;
        ref_long = 1'b0;
        repeat (3) @(negedge clk);
        chk(fb_tick == 1'b0, "R12", "fb_tick in reset", fb_tick, 0);
        chk(ref_tick == 1'b0, "R12", "ref_tick in reset", ref_tick, 0);
        chk(fb_half == 1'b0, "R12", "fb_half in reset", fb_half, 0);
        tick();
        rst_n = 1'b1;
        exp_fb = 17;
        exp_ref = 512;
        running = 1'b1;
        tick();

        // R1: minimum ratio for a few periods.
        repeat (51) rf_edge();
        // R2: ratio below the floor, set mid-period (R4).
        repeat (5) rf_edge();
        div_ratio = 15'd5;
        repeat (60) rf_edge();
        div_ratio = 15'd0;
        repeat (60) rf_edge();
        // R4: larger ratio set mid-period, then back.
        div_ratio = 15'd45;
        repeat (140) rf_edge();
        // R3: bit 14 set in short-word mode gives 23.
        wide_word = 1'b0;
        div_ratio = 15'd16407;
        repeat (100) rf_edge();
        wide_word = 1'b1;
        div_ratio = 15'd30;
        repeat (70) rf_edge();
        // R1, R4: random ratios changed at random points.
        for (int k = 0; k < 140; k++) begin
            div_ratio = 15'(17 + $urandom % 50);
            repeat (1 + $urandom % 80) rf_edge();
        end
        xtal_stop = 1'b1;
        repeat (8) tick();
        running = 1'b0;
        chk(fb_seen > 100, "R1", "feedback ticks seen", fb_seen, 101);
        chk(short_ref_seen > 0, "R5", "short reference periods", short_ref_seen, 1);
        chk(long_ref_seen > 0, "R5", "long reference periods", long_ref_seen, 1);
        finish_run();
    end

endmodule